// File: doc/BRIEF.md
# MSI Write-Invalidate Line Coherence Controller

This block keeps one core's small private cache coherent with its peers on a shared snooping bus. Each cache line is held in one of three states: Modified (the only valid copy, dirty), Shared (a clean copy that others may also hold) or Invalid. Local loads and stores from the core either hit in the line store or turn into bus transactions. Snooped traffic from other cores demotes or drops local copies and, when a dirty copy is involved, pushes its data out so that memory stays current.

The cache is direct-mapped. The low address bits select the line and the remaining bits form the tag. The core holds a request until it sees `cpu_done`. The bus side raises a 2-bit command with an address and holds it until the external arbiter grants it. A read or a read-for-ownership then waits for a fill word from memory. Snoops arrive as a one-cycle command. A dirty hit is answered one cycle later on a separate flush channel. Bus arbitration and the shared memory live outside the block.

Top module: `coh_msi_ctrl`

## Requirements
- R1: After reset every line is Invalid and `bus_cmd` is 00, with `cpu_done`, `cpu_retry` and `flush_valid` all low.
- R2: A load to a line that is absent (Invalid, or another tag) issues bus command 01 (read) with the requested address. After the grant and one fill cycle, the line is Shared and `cpu_rdata` returns the fill word.
- R3: A store to a line that is Invalid or Shared issues bus command 10 (read-for-ownership/invalidate) and leaves the line Modified, with `cpu_rdata` echoing the stored word. A Shared line completes at the grant with no fill. An absent line completes only after a fill.
- R4: A load to a Shared or Modified line, or a store to a Modified line, completes with `cpu_done` in the cycle after acceptance and issues no bus command.
- R5: A snooped read (01) that matches a Modified line raises `flush_valid` one cycle later, carrying the line's address and data, and the line becomes Shared.
- R6: A snooped read that matches a Shared line causes no flush and no state change.
- R7: A snooped invalidate (10) that matches a line makes it Invalid. If the line was Modified, its data is flushed one cycle later.
- R8: A snoop whose tag differs from the stored tag, that targets an Invalid line, or that carries code 00 or 11, changes nothing and causes no flush.
- R9: A miss that displaces a Modified line of another tag first issues bus command 11 (writeback) with the victim's address and data, and then the miss request. A displaced Shared line is dropped with no bus command.
- R10: When a snoop arrives in the same cycle as an idle-state core request to the same line index, the snoop takes effect, `cpu_retry` is high that cycle, and the request is not accepted.
- R11: A bus command and its address stay unchanged until `bus_gnt`. The only exception is a cycle in which a snoop arrives.
- R12: If a pending upgrade's Shared line is invalidated by a snoop before the grant, the store waits for a fill after the grant before it completes.
- R13: If a snoop flushes or invalidates the victim while its writeback still waits for a grant, the writeback is dropped and the miss request follows directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Core request, held until `cpu_done` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_retry | output | 1 | Request refused this cycle because of a same-index snoop |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, or the stored word for a store |
| bus_cmd | output | 2 | 00 none, 01 read, 10 read-for-ownership, 11 writeback |
| bus_addr | output | ADDR_W | Address of the bus command |
| bus_wdata | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Arbiter grant for the current command |
| fill_valid | input | 1 | Memory fill word present |
| fill_data | input | DATA_W | Memory fill word |
| snoop_valid | input | 1 | Snooped transaction from another core |
| snoop_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snoop_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | Dirty data pushed to memory in answer to a snoop |
| flush_addr | output | ADDR_W | Address of the flushed line |
| flush_data | output | DATA_W | Flushed data |

## Verification
The bench targets the points where a local request and a snoop cross. The first is an upgrade whose Shared copy is invalidated while the upgrade waits for the bus. A design that missed this would mark the line Modified over data it no longer owns, and would complete without a fill. The second is a writeback whose victim is flushed by a snoop before the grant. A design that missed this would send a stale duplicate writeback. The third is a same-index snoop and core request in one cycle. Accepting the request there would let the core read a line that the snoop is demoting. The bench also confirms that a Shared victim leaves silently while a Modified one is written back, and that the written-back word is what a later miss reads.

// File: rtl/coh_msi_pkg.sv
package coh_msi_pkg;

    // Line states; the all-zero code is Invalid so reset clears every line.
    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_MOD = 2'b10
    } line_st_e;

    // Bus and snoop command encoding shared with the neighbours on the bus.
    typedef enum logic [1:0] {
        BUS_NONE = 2'b00,
        BUS_RD   = 2'b01,
        BUS_OWN  = 2'b10,
        BUS_WB   = 2'b11
    } bus_cmd_e;

    // Local request sequencer.
    typedef enum logic [1:0] {
        FSM_IDLE = 2'b00,
        FSM_WB   = 2'b01,
        FSM_REQ  = 2'b10,
        FSM_FILL = 2'b11
    } fsm_e;

endpackage

// File: rtl/coh_snoop_eval.sv
module coh_snoop_eval
    import coh_msi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 10,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic                              snoop_valid,
    input  logic [1:0]                        snoop_cmd,
    input  logic [ADDR_W-1:0]                 snoop_addr,
    input  logic [NUM_LINES-1:0][1:0]         lst,
    input  logic [NUM_LINES-1:0][TAG_W-1:0]   ltag,
    output logic                              hit,
    output logic [IDX_W-1:0]                  idx,
    output logic [1:0]                        nxt_st,
    output logic                              flush
);

    logic [TAG_W-1:0] s_tag;
    logic [1:0]       cur;
    logic             present;
    logic             is_rd;
    logic             is_own;

    always_comb begin
        idx     = snoop_addr[IDX_W-1:0];
        s_tag   = snoop_addr[ADDR_W-1:IDX_W];
        cur     = lst[idx];
        present = (ltag[idx] == s_tag) && (cur != LN_INV);
        is_rd   = (snoop_cmd == BUS_RD);
        is_own  = (snoop_cmd == BUS_OWN);
        hit     = snoop_valid && present && (is_rd || is_own);
        // A remote read demotes to Shared; a remote ownership request drops the copy.
        nxt_st  = is_own ? LN_INV : LN_SHR;
        flush   = hit && (cur == LN_MOD);
    end

endmodule

// File: rtl/coh_cpu_eval.sv
module coh_cpu_eval
    import coh_msi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 10,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic                              cpu_write,
    input  logic [ADDR_W-1:0]                 cpu_addr,
    input  logic [NUM_LINES-1:0][1:0]         lst,
    input  logic [NUM_LINES-1:0][TAG_W-1:0]   ltag,
    output logic [IDX_W-1:0]                  idx,
    output logic                              is_hit,
    output logic                              victim_dirty,
    output logic                              upgrade
);

    logic [1:0] cur;
    logic       tag_eq;

    always_comb begin
        idx          = cpu_addr[IDX_W-1:0];
        cur          = lst[idx];
        tag_eq       = (ltag[idx] == cpu_addr[ADDR_W-1:IDX_W]);
        is_hit       = tag_eq && ((cur == LN_MOD) || (cur == LN_SHR && !cpu_write));
        victim_dirty = !tag_eq && (cur == LN_MOD);
        upgrade      = tag_eq && (cur == LN_SHR) && cpu_write;
    end

endmodule

// File: rtl/coh_msi_ctrl.sv
module coh_msi_ctrl
    import coh_msi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_retry,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              flush_valid,
    output logic [ADDR_W-1:0] flush_addr,
    output logic [DATA_W-1:0] flush_data
);

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        fsm_e                             fsm;
        line_st_e [NUM_LINES-1:0]         lst;
        logic [NUM_LINES-1:0][TAG_W-1:0]  ltag;
        logic [NUM_LINES-1:0][DATA_W-1:0] ldata;
        logic                             p_write;
        logic [ADDR_W-1:0]                p_addr;
        logic [DATA_W-1:0]                p_wdata;
        logic                             need_fill;
        bus_cmd_e                         cmd;
        logic [ADDR_W-1:0]                baddr;
        logic [DATA_W-1:0]                bdata;
        logic                             resp;
        logic [DATA_W-1:0]                rdata;
        logic                             flush;
        logic [ADDR_W-1:0]                faddr;
        logic [DATA_W-1:0]                fdata;
    } ctrl_t;

    ctrl_t q, d;

    logic [NUM_LINES-1:0][1:0] lst_flat;
    logic                      snp_hit;
    logic [IDX_W-1:0]          snp_idx;
    logic [1:0]                snp_nxt;
    logic                      snp_flush;
    logic [IDX_W-1:0]          c_idx;
    logic                      c_hit;
    logic                      c_victim_dirty;
    logic                      c_upgrade;
    logic                      collide;
    logic [IDX_W-1:0]          p_idx;
    logic [TAG_W-1:0]          p_tag;

    assign lst_flat = q.lst;

    coh_snoop_eval #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_snoop (
        .snoop_valid (snoop_valid),
        .snoop_cmd   (snoop_cmd),
        .snoop_addr  (snoop_addr),
        .lst         (lst_flat),
        .ltag        (q.ltag),
        .hit         (snp_hit),
        .idx         (snp_idx),
        .nxt_st      (snp_nxt),
        .flush       (snp_flush)
    );

    coh_cpu_eval #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_cpu (
        .cpu_write    (cpu_write),
        .cpu_addr     (cpu_addr),
        .lst          (lst_flat),
        .ltag         (q.ltag),
        .idx          (c_idx),
        .is_hit       (c_hit),
        .victim_dirty (c_victim_dirty),
        .upgrade      (c_upgrade)
    );

    assign p_idx   = q.p_addr[IDX_W-1:0];
    assign p_tag   = q.p_addr[ADDR_W-1:IDX_W];
    // Conservative set-level collision: any snoop on the same index wins.
    assign collide = cpu_valid && snoop_valid &&
                     (snoop_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);

    always_comb begin
        d       = q;
        d.resp  = 1'b0;
        d.flush = 1'b0;

        // Snooped traffic is applied before any local decision this cycle.
        if (snp_hit) begin
            d.lst[snp_idx] = line_st_e'(snp_nxt);
            if (snp_flush) begin
                d.flush = 1'b1;
                d.faddr = snoop_addr;
                d.fdata = q.ldata[snp_idx];
            end
        end

        unique case (q.fsm)
            FSM_IDLE: begin
                if (cpu_valid && !collide) begin
                    if (c_hit) begin
                        d.rdata = cpu_write ? cpu_wdata : q.ldata[c_idx];
                        if (cpu_write) begin
                            d.ldata[c_idx] = cpu_wdata;
                        end
                        d.resp = 1'b1;
                    end else begin
                        d.p_write = cpu_write;
                        d.p_addr  = cpu_addr;
                        d.p_wdata = cpu_wdata;
                        if (c_victim_dirty) begin
                            d.fsm   = FSM_WB;
                            d.cmd   = BUS_WB;
                            d.baddr = {q.ltag[c_idx], c_idx};
                            d.bdata = q.ldata[c_idx];
                        end else if (c_upgrade) begin
                            d.fsm       = FSM_REQ;
                            d.cmd       = BUS_OWN;
                            d.baddr     = cpu_addr;
                            d.need_fill = 1'b0;
                        end else begin
                            d.fsm       = FSM_REQ;
                            d.cmd       = cpu_write ? BUS_OWN : BUS_RD;
                            d.baddr     = cpu_addr;
                            d.need_fill = 1'b1;
                        end
                    end
                end
            end

            FSM_WB: begin
                // A snoop that already took the dirty victim cancels the writeback.
                if (bus_gnt || (d.lst[p_idx] != LN_MOD)) begin
                    if (bus_gnt) begin
                        d.lst[p_idx] = LN_INV;
                    end
                    d.fsm       = FSM_REQ;
                    d.cmd       = q.p_write ? BUS_OWN : BUS_RD;
                    d.baddr     = q.p_addr;
                    d.need_fill = 1'b1;
                end
            end

            FSM_REQ: begin
                // Upgrade lost its Shared copy while waiting: data must be fetched.
                if (!q.need_fill && (d.lst[p_idx] == LN_INV)) begin
                    d.need_fill = 1'b1;
                end
                if (bus_gnt) begin
                    d.cmd = BUS_NONE;
                    if (d.need_fill) begin
                        d.fsm = FSM_FILL;
                    end else begin
                        d.lst[p_idx]   = LN_MOD;
                        d.ldata[p_idx] = q.p_wdata;
                        d.rdata        = q.p_wdata;
                        d.resp         = 1'b1;
                        d.fsm          = FSM_IDLE;
                    end
                end
            end

            FSM_FILL: begin
                if (fill_valid) begin
                    d.ltag[p_idx]  = p_tag;
                    d.ldata[p_idx] = q.p_write ? q.p_wdata : fill_data;
                    d.lst[p_idx]   = q.p_write ? LN_MOD : LN_SHR;
                    d.rdata        = q.p_write ? q.p_wdata : fill_data;
                    d.resp         = 1'b1;
                    d.fsm          = FSM_IDLE;
                end
            end

            default: d.fsm = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_retry   = (q.fsm == FSM_IDLE) && collide;
    assign cpu_done    = q.resp;
    assign cpu_rdata   = q.rdata;
    assign bus_cmd     = q.cmd;
    assign bus_addr    = q.baddr;
    assign bus_wdata   = q.bdata;
    assign flush_valid = q.flush;
    assign flush_addr  = q.faddr;
    assign flush_data  = q.fdata;

endmodule

// File: rtl/coh_msi_ctrl_chk.sv
module coh_msi_ctrl_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_retry,
    input logic              cpu_done,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snoop_valid,
    input logic              flush_valid
);

    // R11: a waiting command keeps its code and address unless a snoop intervenes
    a_r11_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'b00 && !bus_gnt && !snoop_valid) |=>
            (bus_cmd == $past(bus_cmd) && bus_addr == $past(bus_addr)));

    // R5 / R7: a flush is only ever the answer to the previous cycle's snoop
    a_r5_flush_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(snoop_valid));

    // R10: a refused request does not complete in the next cycle
    a_r10_retry_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_retry |=> !cpu_done);

    // R4: completion never coincides with an outstanding bus command
    a_r4_done_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> (bus_cmd == 2'b00));

    // R2: completion only answers a request that was being held
    a_r2_done_has_request: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> $past(cpu_valid));

endmodule

bind coh_msi_ctrl coh_msi_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_valid   (cpu_valid),
    .cpu_retry   (cpu_retry),
    .cpu_done    (cpu_done),
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .bus_gnt     (bus_gnt),
    .snoop_valid (snoop_valid),
    .flush_valid (flush_valid)
);

// File: tb/coh_msi_ctrl_test.sv
`timescale 1ns/1ps
module coh_msi_ctrl_test;

    localparam int AW = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_valid, cpu_write;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_retry, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_gnt, fill_valid;
    logic [DW-1:0] fill_data;
    logic          snoop_valid;
    logic [1:0]    snoop_cmd;
    logic [AW-1:0] snoop_addr;
    logic          flush_valid;
    logic [AW-1:0] flush_addr;
    logic [DW-1:0] flush_data;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    logic [DW-1:0] mem [1024];

    always #2 clk = ~clk;

    coh_msi_ctrl #(.NUM_LINES(4), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_retry(cpu_retry), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .fill_valid(fill_valid),
        .fill_data(fill_data), .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd),
        .snoop_addr(snoop_addr), .flush_valid(flush_valid),
        .flush_addr(flush_addr), .flush_data(flush_data)
    );

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [3:0]    ncmd;
        logic [1:0]    cmd0;
        logic [AW-1:0] addr0;
        logic [DW-1:0] rdata;
    } vec_t;

    // Index = addr[1:0]; tag = addr[9:2]. Memory word at a is 32'hC0DE0000 | a.
    localparam vec_t VEC [11] = '{
        '{1'b0, 10'h004, 32'h0,      4'd1, 2'b01, 10'h004, 32'hC0DE0004}, // R2 cold read
        '{1'b0, 10'h004, 32'h0,      4'd0, 2'b00, 10'h000, 32'hC0DE0004}, // R4 Shared hit
        '{1'b1, 10'h004, 32'h0000AAAA, 4'd1, 2'b10, 10'h004, 32'h0000AAAA}, // R3 upgrade
        '{1'b0, 10'h004, 32'h0,      4'd0, 2'b00, 10'h000, 32'h0000AAAA}, // R4 Modified read
        '{1'b1, 10'h004, 32'h0000BBBB, 4'd0, 2'b00, 10'h000, 32'h0000BBBB}, // R4 Modified write
        '{1'b0, 10'h008, 32'h0,      4'd2, 2'b11, 10'h004, 32'hC0DE0008}, // R9 dirty victim
        '{1'b0, 10'h004, 32'h0,      4'd1, 2'b01, 10'h004, 32'h0000BBBB}, // R9 silent Shared victim
        '{1'b1, 10'h00D, 32'h00001234, 4'd1, 2'b10, 10'h00D, 32'h00001234}, // R3 write miss
        '{1'b0, 10'h00D, 32'h0,      4'd0, 2'b00, 10'h000, 32'h00001234}, // R4 hit after write miss
        '{1'b0, 10'h002, 32'h0,      4'd1, 2'b01, 10'h002, 32'hC0DE0002}, // R2 another index
        '{1'b1, 10'h006, 32'h00005678, 4'd1, 2'b10, 10'h006, 32'h00005678}  // R3 miss over Shared
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int nc, output logic [1:0] c0,
                          output logic [AW-1:0] a0, output int cyc);
        logic          pend;
        logic [AW-1:0] fa;
        pend = 1'b0; fa = '0; nc = 0; c0 = 2'b00; a0 = '0; rd = '0; cyc = 0;
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            cyc = i + 1;
            bus_gnt = 1'b0; fill_valid = 1'b0;
            if (cpu_done) begin
                rd = cpu_rdata;
                break;
            end
            if (pend) begin
                fill_valid = 1'b1; fill_data = mem[fa]; pend = 1'b0;
            end else if (bus_cmd != 2'b00) begin
                if (nc == 0) begin c0 = bus_cmd; a0 = bus_addr; end
                nc++;
                bus_gnt = 1'b1;
                if (bus_cmd == 2'b11) mem[bus_addr] = bus_wdata;
                else begin pend = 1'b1; fa = bus_addr; end
            end
        end
        cpu_valid = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                         output logic fv, output logic [AW-1:0] fa, output logic [DW-1:0] fd);
        snoop_valid = 1'b1; snoop_cmd = c; snoop_addr = a;
        @(negedge clk);
        snoop_valid = 1'b0; snoop_cmd = 2'b00;
        fv = flush_valid; fa = flush_addr; fd = flush_data;
        if (fv) mem[fa] = fd;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        int            nc, cyc;
        logic [1:0]    c0;
        logic [AW-1:0] a0, fa;
        logic          fv;
        logic [DW-1:0] fd;

        for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE0000 | 32'(i);
        rst_n = 1'b0; cpu_valid = 0; cpu_write = 0; cpu_addr = '0; cpu_wdata = '0;
        bus_gnt = 0; fill_valid = 0; fill_data = '0;
        snoop_valid = 0; snoop_cmd = 2'b00; snoop_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 bus_cmd idle", 32'(bus_cmd), 32'd0);
        chk("R1 cpu_done low", 32'(cpu_done), 32'd0);
        chk("R1 flush low", 32'(flush_valid), 32'd0);
        chk("R1 retry low", 32'(cpu_retry), 32'd0);

        // Vector table walk
        for (int v = 0; v < 11; v++) begin
            access(VEC[v].wr, VEC[v].addr, VEC[v].wdata, rd, nc, c0, a0, cyc);
            chk($sformatf("R2/R3/R4/R9 vec%0d bus cmd count", v), 32'(nc), 32'(VEC[v].ncmd));
            chk($sformatf("R2/R3/R4/R9 vec%0d rdata", v), rd, VEC[v].rdata);
            if (VEC[v].ncmd != 0) begin
                chk($sformatf("R2/R3/R9 vec%0d first cmd", v), 32'(c0), 32'(VEC[v].cmd0));
                chk($sformatf("R2/R3/R9 vec%0d first addr", v), 32'(a0), 32'(VEC[v].addr0));
            end else begin
                chk($sformatf("R4 vec%0d hit latency", v), 32'(cyc), 32'd1);
            end
        end
        chk("R9 writeback reached memory", mem[10'h004], 32'h0000BBBB);

        // R5 snoop read on Modified 0x00D
        snoop(2'b01, 10'h00D, fv, fa, fd);
        chk("R5 flush valid", 32'(fv), 32'd1);
        chk("R5 flush addr", 32'(fa), 32'h00D);
        chk("R5 flush data", fd, 32'h00001234);
        access(1'b0, 10'h00D, '0, rd, nc, c0, a0, cyc);
        chk("R5 now Shared read hit", 32'(nc), 32'd0);
        access(1'b1, 10'h00D, 32'h00004321, rd, nc, c0, a0, cyc);
        chk("R5 Shared store upgrades", 32'(c0), 32'd2);

        // R6 snoop read on Shared 0x004
        snoop(2'b01, 10'h004, fv, fa, fd);
        chk("R6 no flush", 32'(fv), 32'd0);
        access(1'b0, 10'h004, '0, rd, nc, c0, a0, cyc);
        chk("R6 still hit", 32'(nc), 32'd0);
        chk("R6 data kept", rd, 32'h0000BBBB);

        // R7 snoop invalidate on Shared then on Modified
        snoop(2'b10, 10'h004, fv, fa, fd);
        chk("R7 Shared inval no flush", 32'(fv), 32'd0);
        access(1'b0, 10'h004, '0, rd, nc, c0, a0, cyc);
        chk("R7 line now Invalid", 32'(c0), 32'd1);
        snoop(2'b10, 10'h00D, fv, fa, fd);
        chk("R7 Modified inval flush", 32'(fv), 32'd1);
        chk("R7 flush data", fd, 32'h00004321);
        access(1'b0, 10'h00D, '0, rd, nc, c0, a0, cyc);
        chk("R7 Modified line now Invalid", 32'(c0), 32'd1);
        chk("R7 refetched data", rd, 32'h00004321);

        // R8 ignored snoops on Modified 0x006
        snoop(2'b10, 10'h00A, fv, fa, fd);
        chk("R8 tag mismatch no flush", 32'(fv), 32'd0);
        snoop(2'b11, 10'h006, fv, fa, fd);
        chk("R8 code 11 no flush", 32'(fv), 32'd0);
        snoop(2'b01, 10'h007, fv, fa, fd);
        chk("R8 Invalid line no flush", 32'(fv), 32'd0);
        access(1'b0, 10'h006, '0, rd, nc, c0, a0, cyc);
        chk("R8 line untouched", 32'(nc), 32'd0);
        chk("R8 data untouched", rd, 32'h00005678);

        // R10 same-index collision
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 10'h006;
        snoop_valid = 1'b1; snoop_cmd = 2'b01; snoop_addr = 10'h006;
        #1;
        chk("R10 retry raised", 32'(cpu_retry), 32'd1);
        @(negedge clk);
        snoop_valid = 1'b0; snoop_cmd = 2'b00; cpu_valid = 1'b0;
        chk("R10 request not accepted", 32'(cpu_done), 32'd0);
        chk("R10 snoop served", 32'(flush_valid), 32'd1);
        chk("R10 snoop data", flush_data, 32'h00005678);
        if (flush_valid) mem[flush_addr] = flush_data;
        access(1'b0, 10'h006, '0, rd, nc, c0, a0, cyc);
        chk("R10 retried request hits", 32'(nc), 32'd0);

        // R12 upgrade loses its copy before grant (line 0x006 is Shared)
        cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 10'h006; cpu_wdata = 32'h00009999;
        @(negedge clk);
        chk("R11 upgrade cmd raised", 32'(bus_cmd), 32'd2);
        snoop_valid = 1'b1; snoop_cmd = 2'b10; snoop_addr = 10'h006;
        @(negedge clk);
        snoop_valid = 1'b0; snoop_cmd = 2'b00;
        chk("R12 Shared inval no flush", 32'(flush_valid), 32'd0);
        chk("R11 cmd held without grant", 32'(bus_cmd), 32'd2);
        chk("R11 addr held without grant", 32'(bus_addr), 32'h006);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        chk("R12 waits for fill", 32'(cpu_done), 32'd0);
        fill_valid = 1'b1; fill_data = mem[10'h006];
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R12 completes after fill", 32'(cpu_done), 32'd1);
        chk("R12 store data", cpu_rdata, 32'h00009999);
        cpu_valid = 1'b0;
        access(1'b0, 10'h006, '0, rd, nc, c0, a0, cyc);
        chk("R12 line Modified", 32'(nc), 32'd0);
        chk("R12 line data", rd, 32'h00009999);

        // R13 victim flushed by snoop while writeback waits
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 10'h00A;
        @(negedge clk);
        chk("R9 writeback cmd", 32'(bus_cmd), 32'd3);
        chk("R9 writeback addr", 32'(bus_addr), 32'h006);
        snoop_valid = 1'b1; snoop_cmd = 2'b01; snoop_addr = 10'h006;
        @(negedge clk);
        snoop_valid = 1'b0; snoop_cmd = 2'b00;
        chk("R13 snoop flush", 32'(flush_valid), 32'd1);
        chk("R13 flush data", flush_data, 32'h00009999);
        if (flush_valid) mem[flush_addr] = flush_data;
        chk("R13 writeback dropped", 32'(bus_cmd), 32'd1);
        chk("R13 miss addr", 32'(bus_addr), 32'h00A);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        fill_valid = 1'b1; fill_data = mem[10'h00A];
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R13 miss completes", 32'(cpu_done), 32'd1);
        chk("R13 miss data", cpu_rdata, 32'hC0DE000A);
        cpu_valid = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule